// File: doc/BRIEF.md
# Trip-Threshold Programming Command Decoder

This block watches the byte-level event stream of a serial slave front end and picks out the special write transactions that program or clear the nonvolatile supply-trip threshold cell. The front end reports a START event, a STOP event, and each received byte together with its position in the transaction. Position 0 is the slave address. The decoder also sees two levels: a flag that says a high programming voltage is present on the write-protect pin, and the write-enable latch bit.

A transaction counts as a threshold command only when the high-voltage flag was already present before its START. Its three bytes must be the slave identifier A0h, then a register selector, then the key byte 00h. Selector 01h requests a raise (program) and selector 03h requests a clear (reset to the lowest nominal threshold). On the STOP that closes a valid transaction, and only while the write-enable latch is set, the block emits a one-cycle command strobe to the trip-cell controller. It then holds a busy flag until the high-voltage flag goes away.

No memory-array write request ever comes from this block. Any deviation from the exact sequence sends the recognizer back to idle at once.

Top module: `trip_prog_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `prog_strobe`, `clear_strobe` and `trip_busy` are 0.
- R2: A START begins recognition only if `hv_on_wp` was high at the ARM_CYCLES (default 2) rising edges before the START cycle and is also high in the START cycle. A START without this arming produces no strobe for that whole transaction.
- R3: The byte sequence A0h at index 0, then 01h at index 1, then 00h at index 2, closed by STOP with `wel_bit` high, makes `prog_strobe` high for exactly one cycle, in the cycle after the STOP is sampled. `clear_strobe` stays 0.
- R4: The same sequence with 03h at index 1 makes `clear_strobe` high for exactly one cycle, in the cycle after the STOP. `prog_strobe` stays 0.
- R5: A byte value other than the expected one at any position (slave identifier, selector not 01h or 03h, key not 00h) returns the recognizer to idle, and no strobe follows.
- R6: A byte whose index is not the next expected one, or a fourth byte before STOP, returns the recognizer to idle, and no strobe follows.
- R7: A repeated START before STOP aborts recognition. The bytes and STOP that follow it produce no strobe. A later START that is properly armed begins a fresh recognition.
- R8: If `wel_bit` is low in the STOP cycle, no strobe is issued and `trip_busy` stays 0.
- R9: `trip_busy` rises in the same cycle as a strobe and stays high while `hv_on_wp` is high. It falls in the cycle after `hv_on_wp` is sampled low.
- R10: If `hv_on_wp` goes low at any point between START and STOP, recognition is aborted and no strobe follows.
- R11: While `trip_busy` is high, new transactions are ignored and produce no strobe.
- R12: The two strobes are never high together, and a strobe is high only in the cycle right after a STOP event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | One-cycle START event from the front end |
| ev_stop | input | 1 | One-cycle STOP event from the front end |
| ev_byte | input | 1 | One-cycle received-byte event |
| byte_val | input | BYTE_W | Received byte value, valid with `ev_byte` |
| byte_idx | input | IDX_W | Position of the byte in the transaction, 0 = slave address |
| hv_on_wp | input | 1 | High programming voltage present on the write-protect pin |
| wel_bit | input | 1 | Write-enable latch state |
| prog_strobe | output | 1 | One-cycle raise-threshold command |
| clear_strobe | output | 1 | One-cycle clear-threshold command |
| trip_busy | output | 1 | Operation in progress, waiting for the high voltage to be removed |

## Verification
A wrong recognizer state shows up at the strobes on the STOP that closes a transaction. A stuck or skipped state either fires a strobe where the reference expects none, or misses one, in the cycle right after that STOP. A wrong selector memory shows up as the wrong strobe in that same cycle. A wrong arming count or hold logic shows up as a busy flag that rises when it should not, or does not fall in the cycle after the high voltage is removed. The bench compares all three outputs against its model on every cycle, so any of these errors is reported within one clock of the event that exposes it.

// File: rtl/trip_pkg.sv
package trip_pkg;
  typedef enum logic [2:0] {
    M_IDLE,
    M_SLAVE,
    M_SELECT,
    M_KEY,
    M_CLOSE
  } match_st_e;

  typedef enum logic {
    OP_RAISE,
    OP_CLEAR
  } trip_op_e;
endpackage

// File: rtl/hv_arm_tracker.sv
module hv_arm_tracker #(
  parameter int ARM_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hv_on_wp,
  output logic armed
);
  generate
    if (ARM_CYCLES == 0) begin : g_direct
      assign armed = hv_on_wp;
    end else begin : g_count
      localparam int CNT_W = $clog2(ARM_CYCLES + 1);
      logic [CNT_W-1:0] run_cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          run_cnt <= '0;
        end else if (!hv_on_wp) begin
          run_cnt <= '0;
        end else if (run_cnt != CNT_W'(ARM_CYCLES)) begin
          run_cnt <= run_cnt + 1'b1;
        end
      end

      assign armed = hv_on_wp && (run_cnt == CNT_W'(ARM_CYCLES));
    end
  endgenerate
endmodule

// File: rtl/trip_seq_matcher.sv
module trip_seq_matcher
  import trip_pkg::*;
#(
  parameter int             BYTE_W     = 8,
  parameter int             IDX_W      = 2,
  parameter logic [BYTE_W-1:0] SLAVE_ID   = 8'hA0,
  parameter logic [BYTE_W-1:0] RAISE_SEL  = 8'h01,
  parameter logic [BYTE_W-1:0] CLEAR_SEL  = 8'h03,
  parameter logic [BYTE_W-1:0] KEY_BYTE   = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic              hv_on_wp,
  input  logic              armed,
  input  logic              busy,
  input  logic              wel_bit,
  output logic              fire,
  output trip_op_e          fire_op
);
  localparam logic [IDX_W-1:0] IDX_SLAVE  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_SELECT = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_KEY    = IDX_W'(2);

  match_st_e st, st_nxt;
  trip_op_e  op_q;
  logic      sel_ok, sel_clear;

  assign sel_clear = (byte_val == CLEAR_SEL);
  assign sel_ok    = (byte_val == RAISE_SEL) || sel_clear;

  always_comb begin
    st_nxt = st;
    fire   = 1'b0;
    if (st == M_IDLE) begin
      if (ev_start && armed && !busy) st_nxt = M_SLAVE;
    end else if (!hv_on_wp || ev_start) begin
      st_nxt = M_IDLE;
    end else if (ev_stop) begin
      st_nxt = M_IDLE;
      fire   = (st == M_CLOSE) && wel_bit;
    end else if (ev_byte) begin
      unique case (st)
        M_SLAVE:  st_nxt = (byte_idx == IDX_SLAVE && byte_val == SLAVE_ID) ? M_SELECT : M_IDLE;
        M_SELECT: st_nxt = (byte_idx == IDX_SELECT && sel_ok) ? M_KEY : M_IDLE;
        M_KEY:    st_nxt = (byte_idx == IDX_KEY && byte_val == KEY_BYTE) ? M_CLOSE : M_IDLE;
        default:  st_nxt = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= M_IDLE;
      op_q <= OP_RAISE;
    end else begin
      st <= st_nxt;
      if (st == M_SELECT && ev_byte && !ev_start && !ev_stop)
        op_q <= sel_clear ? OP_CLEAR : OP_RAISE;
    end
  end

  assign fire_op = op_q;
endmodule

// File: rtl/trip_cmd_issuer.sv
module trip_cmd_issuer
  import trip_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fire,
  input  trip_op_e fire_op,
  input  logic     hv_on_wp,
  output logic     prog_strobe,
  output logic     clear_strobe,
  output logic     busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_strobe  <= 1'b0;
      clear_strobe <= 1'b0;
      busy         <= 1'b0;
    end else begin
      prog_strobe  <= fire && (fire_op == OP_RAISE);
      clear_strobe <= fire && (fire_op == OP_CLEAR);
      if (fire)           busy <= 1'b1;
      else if (!hv_on_wp) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/trip_prog_decoder.sv
module trip_prog_decoder
  import trip_pkg::*;
#(
  parameter int             BYTE_W     = 8,
  parameter int             IDX_W      = 2,
  parameter int             ARM_CYCLES = 2,
  parameter logic [BYTE_W-1:0] SLAVE_ID   = 8'hA0,
  parameter logic [BYTE_W-1:0] RAISE_SEL  = 8'h01,
  parameter logic [BYTE_W-1:0] CLEAR_SEL  = 8'h03,
  parameter logic [BYTE_W-1:0] KEY_BYTE   = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic              hv_on_wp,
  input  logic              wel_bit,
  output logic              prog_strobe,
  output logic              clear_strobe,
  output logic              trip_busy
);
  logic     armed;
  logic     fire;
  trip_op_e fire_op;

  hv_arm_tracker #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk      (clk),
    .rst      (rst),
    .hv_on_wp (hv_on_wp),
    .armed    (armed)
  );

  trip_seq_matcher #(
    .BYTE_W    (BYTE_W),
    .IDX_W     (IDX_W),
    .SLAVE_ID  (SLAVE_ID),
    .RAISE_SEL (RAISE_SEL),
    .CLEAR_SEL (CLEAR_SEL),
    .KEY_BYTE  (KEY_BYTE)
  ) u_match (
    .clk      (clk),
    .rst      (rst),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_byte  (ev_byte),
    .byte_val (byte_val),
    .byte_idx (byte_idx),
    .hv_on_wp (hv_on_wp),
    .armed    (armed),
    .busy     (trip_busy),
    .wel_bit  (wel_bit),
    .fire     (fire),
    .fire_op  (fire_op)
  );

  trip_cmd_issuer u_issue (
    .clk          (clk),
    .rst          (rst),
    .fire         (fire),
    .fire_op      (fire_op),
    .hv_on_wp     (hv_on_wp),
    .prog_strobe  (prog_strobe),
    .clear_strobe (clear_strobe),
    .busy         (trip_busy)
  );
endmodule

// File: rtl/trip_prog_decoder_chk.sv
module trip_prog_decoder_chk #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              ev_byte,
  input logic [BYTE_W-1:0] byte_val,
  input logic [IDX_W-1:0]  byte_idx,
  input logic              hv_on_wp,
  input logic              wel_bit,
  input logic              prog_strobe,
  input logic              clear_strobe,
  input logic              trip_busy
);
  p_prog_single_r3: assert property (@(posedge clk) disable iff (rst)
    prog_strobe |=> !prog_strobe);

  p_clear_single_r4: assert property (@(posedge clk) disable iff (rst)
    clear_strobe |=> !clear_strobe);

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(prog_strobe && clear_strobe));

  p_after_stop_r12: assert property (@(posedge clk) disable iff (rst)
    (prog_strobe || clear_strobe) |-> $past(ev_stop));

  p_wel_needed_r8: assert property (@(posedge clk) disable iff (rst)
    (prog_strobe || clear_strobe) |-> $past(wel_bit));

  p_hv_needed_r2: assert property (@(posedge clk) disable iff (rst)
    (prog_strobe || clear_strobe) |-> $past(hv_on_wp));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (trip_busy && hv_on_wp) |=> trip_busy);

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (trip_busy && !hv_on_wp) |=> !trip_busy);

  p_busy_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    trip_busy |=> !(prog_strobe || clear_strobe));
endmodule

bind trip_prog_decoder trip_prog_decoder_chk #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/trip_prog_decoder_test.sv
`timescale 1ns/1ps
module trip_prog_decoder_test;
  localparam int ARM = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       st = 1'b0, sp = 1'b0, bv = 1'b0;
  logic [7:0] bd = 8'h00;
  logic [1:0] bi = 2'd0;
  logic       hv = 1'b0, wel = 1'b1;
  logic       prog_o, clr_o, busy_o;

  int checks = 0, fails = 0;
  int n_prog = 0, n_clr = 0;
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  trip_prog_decoder uut (
    .clk(clk), .rst(rst), .ev_start(st), .ev_stop(sp), .ev_byte(bv),
    .byte_val(bd), .byte_idx(bi), .hv_on_wp(hv), .wel_bit(wel),
    .prog_strobe(prog_o), .clear_strobe(clr_o), .trip_busy(busy_o)
  );

  // behavioural reference: collects bytes in a queue and judges prefixes
  int          hv_run = 0;
  bit          act = 0, m_busy = 0, e_prog = 0, e_clr = 0;
  logic [7:0]  q[$];

  always @(posedge clk) begin
    bit armed_now, ok;
    armed_now = (hv_run >= ARM) && hv;
    e_prog = 0;
    e_clr  = 0;
    if (rst) begin
      act = 0; m_busy = 0; q.delete();
    end else if (m_busy) begin
      if (!hv) m_busy = 0;
    end else if (act) begin
      if (!hv || st) act = 0;
      else if (sp) begin
        act = 0;
        if (q.size() == 3 && wel) begin
          if (q[1] == 8'h01) e_prog = 1; else e_clr = 1;
          m_busy = 1;
        end
      end else if (bv) begin
        ok = (int'(bi) == q.size()) && (q.size() < 3);
        if (ok) begin
          case (q.size())
            0: ok = (bd == 8'hA0);
            1: ok = (bd == 8'h01) || (bd == 8'h03);
            default: ok = (bd == 8'h00);
          endcase
        end
        if (ok) q.push_back(bd); else act = 0;
      end
    end else if (st && armed_now) begin
      act = 1; q.delete();
    end
    if (rst || !hv) hv_run = 0;
    else if (hv_run < 1000) hv_run = hv_run + 1;
  end

  task automatic check(string req, int actual, int expected, string what);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, prog_o, e_prog, "cycle prog_strobe");
      check(cur_req, clr_o, e_clr, "cycle clear_strobe");
      check(cur_req, busy_o, m_busy, "cycle trip_busy");
      if (prog_o) n_prog++;
      if (clr_o)  n_clr++;
    end
  end

  task automatic gap(int n); repeat (n) @(negedge clk); endtask
  task automatic ev_s(); @(negedge clk); #2 st = 1; @(negedge clk); #2 st = 0; endtask
  task automatic ev_p(); @(negedge clk); #2 sp = 1; @(negedge clk); #2 sp = 0; endtask
  task automatic ev_b(input logic [1:0] i, input logic [7:0] d);
    @(negedge clk); #2 bv = 1; bi = i; bd = d;
    @(negedge clk); #2 bv = 0;
  endtask
  task automatic xfer(input logic [7:0] b0, b1, b2);
    ev_s(); ev_b(2'd0, b0); ev_b(2'd1, b1); ev_b(2'd2, b2); ev_p();
  endtask
  task automatic arm();    @(negedge clk); #2 hv = 1; gap(4); endtask
  task automatic disarm(); @(negedge clk); #2 hv = 0; gap(3); endtask
  task automatic zero();   n_prog = 0; n_clr = 0; endtask
  task automatic counts(string req, int ep, int ec);
    gap(2);
    check(req, n_prog, ep, "prog strobe count");
    check(req, n_clr, ec, "clear strobe count");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    gap(4);
    check("R1", {29'd0, prog_o, clr_o, busy_o}, 0, "outputs in reset");
    @(negedge clk); #2 rst = 0;
    @(negedge clk);
    check("R1", {29'd0, prog_o, clr_o, busy_o}, 0, "outputs after reset");

    cur_req = "R3"; arm(); zero();
    xfer(8'hA0, 8'h01, 8'h00); counts("R3", 1, 0);
    cur_req = "R9"; check("R9", busy_o, 1, "busy after program");
    gap(5); check("R9", busy_o, 1, "busy held with hv");
    disarm(); check("R9", busy_o, 0, "busy after hv removed");

    cur_req = "R4"; arm(); zero();
    xfer(8'hA0, 8'h03, 8'h00); counts("R4", 0, 1);
    disarm();

    cur_req = "R2"; zero();
    @(negedge clk); #2 hv = 1; st = 1;
    @(negedge clk); #2 st = 0;
    ev_b(2'd0, 8'hA0); ev_b(2'd1, 8'h01); ev_b(2'd2, 8'h00); ev_p();
    counts("R2", 0, 0);
    xfer(8'hA0, 8'h01, 8'h00); counts("R2", 1, 0);
    disarm();

    cur_req = "R5"; arm(); zero();
    xfer(8'hA2, 8'h01, 8'h00);
    xfer(8'hA0, 8'h02, 8'h00);
    xfer(8'hA0, 8'h01, 8'h05);
    counts("R5", 0, 0);
    check("R5", busy_o, 0, "busy after bad values");

    cur_req = "R6"; zero();
    ev_s(); ev_b(2'd0, 8'hA0); ev_b(2'd1, 8'h01); ev_b(2'd2, 8'h00); ev_b(2'd3, 8'h00); ev_p();
    ev_s(); ev_b(2'd0, 8'hA0); ev_b(2'd2, 8'h01); ev_b(2'd2, 8'h00); ev_p();
    counts("R6", 0, 0);

    cur_req = "R7"; zero();
    ev_s(); ev_b(2'd0, 8'hA0); ev_s(); ev_b(2'd1, 8'h01); ev_b(2'd2, 8'h00); ev_p();
    counts("R7", 0, 0);
    xfer(8'hA0, 8'h03, 8'h00); counts("R7", 0, 1);
    disarm();

    cur_req = "R8"; arm(); zero();
    @(negedge clk); #2 wel = 0;
    xfer(8'hA0, 8'h01, 8'h00); counts("R8", 0, 0);
    check("R8", busy_o, 0, "busy without write enable");
    @(negedge clk); #2 wel = 1;

    cur_req = "R10"; zero();
    ev_s(); ev_b(2'd0, 8'hA0); ev_b(2'd1, 8'h01); ev_b(2'd2, 8'h00);
    @(negedge clk); #2 hv = 0;
    @(negedge clk); #2 hv = 1;
    ev_p(); counts("R10", 0, 0);
    gap(3);

    cur_req = "R11"; zero();
    xfer(8'hA0, 8'h01, 8'h00); counts("R11", 1, 0);
    zero();
    xfer(8'hA0, 8'h03, 8'h00); counts("R11", 0, 0);
    check("R11", busy_o, 1, "busy kept during ignored transaction");
    disarm();

    cur_req = "R12"; arm(); zero();
    xfer(8'hA0, 8'h01, 8'h00); counts("R12", 1, 0);
    disarm();

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule